// File: doc/BRIEF.md
# Single-Cycle Hardwired Control Decoder

This block turns the opcode and function fields of a 32-bit instruction, together with the ALU zero flag, into the complete set of select and enable signals a single-cycle load/store datapath with separate instruction and data memories needs in one cycle. It is purely combinational. The signals it drives are:

- the immediate extension mode
- the ALU B-operand source
- the ALU operation source
- data-memory write enable
- register-file write enable
- the write-back source
- the destination-register select
- the next-PC source

Supported instructions fall into seven groups:

- register-register ALU operations
- signed-immediate ALU operations
- unsigned-immediate ALU operations
- word load and word store
- the zero-test branches BEQZ and BNEZ
- the absolute jumps J and JAL
- the register-indirect jumps JR and JALR

The two linking jumps write the PC-derived return value into register 31. An opcode or function code outside the supported set is reported on `illegal`. In that case the decoder holds every state-changing enable low and lets the PC advance sequentially.

Opcode map: 0x00 register-register (function field decoded), 0x02 J, 0x03 JAL, 0x04 BEQZ, 0x05 BNEZ, 0x08 and 0x0A signed-immediate ALU, 0x0C, 0x0D and 0x0E unsigned-immediate ALU, 0x12 JR, 0x13 JALR, 0x23 load word, 0x2B store word. Legal function codes under opcode 0: 0x00, 0x02, 0x03, 0x20 through 0x26, 0x2A and 0x2B.

Field encodings:

| Field | Width | Values |
|-------|-------|--------|
| `ext_sel` | 2 bits | 0 sign-extend 16, 1 zero-extend 16, 2 upper 16 |
| `b_sel` | 1 bit | 0 register, 1 immediate |
| `alu_sel` | 2 bits | 0 from function field, 1 from opcode, 2 add, 3 zero test |
| `wb_sel` | 2 bits | 0 ALU, 1 memory, 2 PC link |
| `dst_sel` | 2 bits | 0 rt, 1 rd, 2 register 31 |
| `pc_sel` | 2 bits | 0 PC+4, 1 branch target, 2 register-indirect, 3 absolute |

When a field does not matter for an instruction, it is driven to 0.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 0x00 with a legal function code gives `b_sel`=0, `alu_sel`=0, `reg_we`=1, `wb_sel`=0, `dst_sel`=1, `pc_sel`=0, `mem_we`=0, `ext_sel`=0, `illegal`=0.
- R2: Opcodes 0x08 and 0x0A give `ext_sel`=0, `b_sel`=1, `alu_sel`=1, `reg_we`=1, `wb_sel`=0, `dst_sel`=0, `pc_sel`=0, `mem_we`=0.
- R3: Opcodes 0x0C, 0x0D and 0x0E give the same outputs as R2, except that `ext_sel` is 1 (zero extension).
- R4: Opcode 0x23 (load) gives `ext_sel`=0, `b_sel`=1, `alu_sel`=2, `mem_we`=0, `reg_we`=1, `wb_sel`=1, `dst_sel`=0, `pc_sel`=0.
- R5: Opcode 0x2B (store) gives `ext_sel`=0, `b_sel`=1, `alu_sel`=2, `mem_we`=1, `reg_we`=0, `pc_sel`=0.
- R6: For opcode 0x04 (BEQZ) and 0x05 (BNEZ), `alu_sel`=3 and `ext_sel`=0 with both writes low. `pc_sel` is 1 when `zero`=1 for BEQZ, or `zero`=0 for BNEZ, and 0 otherwise.
- R7: Opcode 0x02 (J) gives `pc_sel`=3 with no writes. Opcode 0x03 (JAL) also gives `pc_sel`=3, and additionally `reg_we`=1, `wb_sel`=2, `dst_sel`=2.
- R8: Opcode 0x12 (JR) gives `pc_sel`=2 with no writes. Opcode 0x13 (JALR) also gives `pc_sel`=2, and additionally `reg_we`=1, `wb_sel`=2, `dst_sel`=2.
- R9: An opcode outside the map gives `illegal`=1, `mem_we`=0, `reg_we`=0 and `pc_sel`=0.
- R10: Opcode 0x00 with a function code outside the legal list gives `illegal`=1, `mem_we`=0, `reg_we`=0 and `pc_sel`=0.
- R11: For every opcode other than 0x04 and 0x05, `zero` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction bits 31:26 |
| funct | input | 6 | Instruction bits 5:0 |
| zero | input | 1 | ALU result-is-zero flag |
| ext_sel | output | 2 | Immediate extension mode |
| b_sel | output | 1 | ALU B-operand source |
| alu_sel | output | 2 | ALU operation source |
| mem_we | output | 1 | Data-memory write enable |
| reg_we | output | 1 | Register-file write enable |
| wb_sel | output | 2 | Write-back data source |
| dst_sel | output | 2 | Destination register select |
| pc_sel | output | 2 | Next-PC source |
| illegal | output | 1 | Unsupported instruction |

## Verification
The hardest situations to reach are the two that depend on a second input that most instructions ignore. The first is the branch PC source, which flips with the zero flag. The second is the illegal result under opcode 0, which depends on the function field. The stimulus therefore drives every branch with both flag values. It also sweeps every legal and several illegal function codes under opcode 0. Finally, it replays each non-branch instruction with the flag toggled and expects an identical control vector.

// File: rtl/ctrl_decoder.sv
module ctrl_decoder (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       zero,
  output logic [1:0] ext_sel,
  output logic       b_sel,
  output logic [1:0] alu_sel,
  output logic       mem_we,
  output logic       reg_we,
  output logic [1:0] wb_sel,
  output logic [1:0] dst_sel,
  output logic [1:0] pc_sel,
  output logic       illegal
);
  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQZ  = 6'h04;
  localparam logic [5:0] OP_BNEZ  = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_JR    = 6'h12;
  localparam logic [5:0] OP_JALR  = 6'h13;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [1:0] EXT_S16 = 2'd0, EXT_U16 = 2'd1;
  localparam logic [1:0] ALU_FN = 2'd0, ALU_OP = 2'd1, ALU_ADD = 2'd2, ALU_ZT = 2'd3;
  localparam logic [1:0] WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC = 2'd2;
  localparam logic [1:0] DST_RT = 2'd0, DST_RD = 2'd1, DST_LNK = 2'd2;
  localparam logic [1:0] PC_SEQ = 2'd0, PC_BR = 2'd1, PC_IND = 2'd2, PC_ABS = 2'd3;

  logic fn_ok;
  always_comb begin
    case (funct)
      6'h00, 6'h02, 6'h03,
      6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26,
      6'h2A, 6'h2B: fn_ok = 1'b1;
      default:      fn_ok = 1'b0;
    endcase
  end

  always_comb begin
    ext_sel = EXT_S16;
    b_sel   = 1'b0;
    alu_sel = ALU_FN;
    mem_we  = 1'b0;
    reg_we  = 1'b0;
    wb_sel  = WB_ALU;
    dst_sel = DST_RT;
    pc_sel  = PC_SEQ;
    illegal = 1'b0;
    case (opcode)
      OP_REG: begin
        if (fn_ok) begin
          reg_we  = 1'b1;
          dst_sel = DST_RD;
        end else begin
          illegal = 1'b1;
        end
      end
      OP_ADDI, OP_SLTI: begin
        b_sel = 1'b1; alu_sel = ALU_OP; reg_we = 1'b1;
      end
      OP_ANDI, OP_ORI, OP_XORI: begin
        ext_sel = EXT_U16; b_sel = 1'b1; alu_sel = ALU_OP; reg_we = 1'b1;
      end
      OP_LW: begin
        b_sel = 1'b1; alu_sel = ALU_ADD; reg_we = 1'b1; wb_sel = WB_MEM;
      end
      OP_SW: begin
        b_sel = 1'b1; alu_sel = ALU_ADD; mem_we = 1'b1;
      end
      OP_BEQZ: begin
        alu_sel = ALU_ZT;
        pc_sel  = zero ? PC_BR : PC_SEQ;
      end
      OP_BNEZ: begin
        alu_sel = ALU_ZT;
        pc_sel  = zero ? PC_SEQ : PC_BR;
      end
      OP_J:    pc_sel = PC_ABS;
      OP_JAL: begin
        pc_sel = PC_ABS; reg_we = 1'b1; wb_sel = WB_PC; dst_sel = DST_LNK;
      end
      OP_JR:   pc_sel = PC_IND;
      OP_JALR: begin
        pc_sel = PC_IND; reg_we = 1'b1; wb_sel = WB_PC; dst_sel = DST_LNK;
      end
      default: illegal = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({opcode, funct, zero})) begin
      AST_ILLEGAL_QUIET: assert (!illegal || (!mem_we && !reg_we && pc_sel == PC_SEQ)); // R9
      AST_SINGLE_WRITE: assert (!(mem_we && reg_we)); // R5
      AST_LINK_FROM_PC: assert (dst_sel != DST_LNK || (wb_sel == WB_PC && reg_we)); // R7
      AST_BRANCH_COND: assert (pc_sel != PC_BR ||
        (opcode == OP_BEQZ && zero) || (opcode == OP_BNEZ && !zero)); // R6
      AST_LOAD_TARGET: assert (wb_sel != WB_MEM || (dst_sel == DST_RT && opcode == OP_LW)); // R4
    end
  end
endmodule

// File: tb/sim_ctrl_decoder.sv
module sim_ctrl_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [5:0] opcode, funct;
  logic       zero;
  logic [1:0] ext_sel, alu_sel, wb_sel, dst_sel, pc_sel;
  logic       b_sel, mem_we, reg_we, illegal;
  int checks = 0;
  int errors = 0;

  ctrl_decoder u0 (
    .opcode(opcode), .funct(funct), .zero(zero),
    .ext_sel(ext_sel), .b_sel(b_sel), .alu_sel(alu_sel),
    .mem_we(mem_we), .reg_we(reg_we), .wb_sel(wb_sel),
    .dst_sel(dst_sel), .pc_sel(pc_sel), .illegal(illegal)
  );

  // vector layout: ext,b,alu,mem,reg,wb,dst,pc,ill (14 bits)
  function automatic logic [13:0] mk(input logic [1:0] e, input logic b, input logic [1:0] a,
                                     input logic m, input logic r, input logic [1:0] w,
                                     input logic [1:0] d, input logic [1:0] p, input logic i);
    return {e, b, a, m, r, w, d, p, i};
  endfunction

  function automatic logic [13:0] got();
    return {ext_sel, b_sel, alu_sel, mem_we, reg_we, wb_sel, dst_sel, pc_sel, illegal};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z);
    @(posedge clk);
    opcode = op; funct = fn; zero = z;
    @(negedge clk);
  endtask

  task automatic expect_vec(input string req, input logic [13:0] exp);
    checks++;
    if (got() !== exp) begin
      errors++;
      $display("FAIL %s op=%h fn=%h z=%b actual=%b expected=%b", req, opcode, funct, zero, got(), exp);
    end
  endtask

  task automatic test_regreg();
    logic [5:0] fns [12] = '{6'h00, 6'h02, 6'h03, 6'h20, 6'h21, 6'h22, 6'h23,
                             6'h24, 6'h25, 6'h26, 6'h2A, 6'h2B};
    for (int k = 0; k < 12; k++) begin
      apply(6'h00, fns[k], k[0]);
      expect_vec("R1", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0, 1'b0));
    end
  endtask

  task automatic test_imm();
    apply(6'h08, 6'h15, 1'b0);
    expect_vec("R2", mk(2'd0, 1'b1, 2'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0));
    apply(6'h0A, 6'h3F, 1'b1);
    expect_vec("R2", mk(2'd0, 1'b1, 2'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0));
    for (int k = 12; k <= 14; k++) begin
      apply(6'(k), 6'h07, 1'b0);
      expect_vec("R3", mk(2'd1, 1'b1, 2'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0));
    end
  endtask

  task automatic test_mem();
    apply(6'h23, 6'h00, 1'b0);
    expect_vec("R4", mk(2'd0, 1'b1, 2'd2, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 1'b0));
    apply(6'h2B, 6'h00, 1'b1);
    expect_vec("R5", mk(2'd0, 1'b1, 2'd2, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0));
  endtask

  task automatic test_branch();
    apply(6'h04, 6'h00, 1'b1);
    expect_vec("R6", mk(2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 1'b0));
    apply(6'h04, 6'h00, 1'b0);
    expect_vec("R6", mk(2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0));
    apply(6'h05, 6'h00, 1'b1);
    expect_vec("R6", mk(2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0));
    apply(6'h05, 6'h00, 1'b0);
    expect_vec("R6", mk(2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 1'b0));
  endtask

  task automatic test_jumps();
    apply(6'h02, 6'h00, 1'b0);
    expect_vec("R7", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 1'b0));
    apply(6'h03, 6'h00, 1'b0);
    expect_vec("R7", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd3, 1'b0));
    apply(6'h12, 6'h00, 1'b0);
    expect_vec("R8", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 1'b0));
    apply(6'h13, 6'h00, 1'b0);
    expect_vec("R8", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 1'b0));
  endtask

  task automatic test_illegal();
    logic [5:0] ops [4] = '{6'h01, 6'h10, 6'h22, 6'h3F};
    logic [5:0] fns [4] = '{6'h01, 6'h08, 6'h27, 6'h3F};
    for (int k = 0; k < 4; k++) begin
      apply(ops[k], 6'h20, k[0]);
      expect_vec("R9", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1));
    end
    for (int k = 0; k < 4; k++) begin
      apply(6'h00, fns[k], k[0]);
      expect_vec("R10", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1));
    end
  endtask

  task automatic test_zero_ignored();
    logic [5:0] ops [12] = '{6'h00, 6'h02, 6'h03, 6'h08, 6'h0A, 6'h0C,
                             6'h0E, 6'h12, 6'h13, 6'h23, 6'h2B, 6'h30};
    for (int k = 0; k < 12; k++) begin
      logic [13:0] first;
      apply(ops[k], 6'h25, 1'b0);
      first = got();
      apply(ops[k], 6'h25, 1'b1);
      expect_vec("R11", first);
    end
  endtask

  initial begin
    opcode = 6'h00; funct = 6'h20; zero = 1'b0;
    @(negedge clk);
    expect_vec("R1", mk(2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0, 1'b0));
    test_regreg();
    test_imm();
    test_mem();
    test_branch();
    test_jumps();
    test_illegal();
    test_zero_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule